// File: doc/BRIEF.md
# Write-Only I2C Word Receiver

This block is an I2C target that only accepts writes. It samples SCL and SDA with the system clock through short synchronizers and finds START, STOP and SCL edges in that clock domain. It compares the 7-bit address in the first byte of a frame with a strap address supplied on an input and with a fixed broadcast address. After a write to either address it takes in exactly three data bytes, each acknowledged. It then presents them as one 24-bit word, together with a one-cycle valid strobe.

The block only ever drives SDA low, and only during an acknowledge bit. It does so through an open-drain enable that the pad logic turns into a pull-down. Reads are never acknowledged. Bytes past the third are refused. A START or STOP arriving partway through a frame drops whatever has been gathered so far.

Top module: `i2c_word_rx`

## Requirements
- R1: After reset, `sda_oe` is 0 and `word_vld` is 0.
- R2: After a write to the strap address, each of the three data bytes is acknowledged. `word_vld` then pulses once, and `word_o` holds byte 1 in [23:16], byte 2 in [15:8] and byte 3 in [7:0]. Bytes are sent MSB first and sampled on SCL rising edges.
- R3: An address byte whose upper seven bits equal the strap address or the broadcast address 7'h73, and whose bit 0 (R/W) is 0, is acknowledged by pulling SDA low during the 9th clock.
- R4: An address byte whose seven address bits match neither address is not acknowledged. No word follows from that frame.
- R5: A matching address with R/W equal to 1 is not acknowledged. The block acknowledges nothing and produces no word until the next START.
- R6: A fourth or later data byte in the same frame is not acknowledged, and no further word is produced.
- R7: A STOP before the third data byte is complete discards the frame without producing a word.
- R8: A repeated START before the third data byte is complete discards the frame. The new frame that it begins is then handled normally.
- R9: `word_vld` is high for exactly one clock cycle per word.
- R10: `sda_oe` rises only after the SCL falling edge that ends the 8th bit of a byte. It falls after the SCL falling edge that ends the 9th bit. Both changes therefore happen while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_addr | input | 7 | Own 7-bit target address |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| word_o | output | 24 | Last received word |
| word_vld | output | 1 | One-cycle strobe for a new word |

## Verification
The timing checks assume that each SCL low phase lasts several system clocks longer than the synchronizer delay. They also assume that the controller changes SDA only while SCL is low, except when it signals START or STOP. The bench holds each quarter of a bit for eight system clocks, and it moves SDA only in the middle of an SCL low phase. The bench models the SDA line as wired-AND, so the level it reads back during an acknowledge clock is the actual bus level.

// File: rtl/i2c_word_rx.sv
module i2c_word_rx #(
  parameter logic [6:0] GLOBAL_ADDR = 7'h73,
  parameter int         SYNC        = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [6:0]  strap_addr,
  output logic        sda_oe,
  output logic [23:0] word_o,
  output logic        word_vld
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} state_t;

  logic [SYNC:0] scl_s, sda_s;
  state_t        st;
  logic [3:0]    bit_cnt;
  logic [1:0]    nbyte;
  logic [7:0]    shf;
  logic [15:0]   hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[SYNC-1:0], scl_i};
      sda_s <= {sda_s[SYNC-1:0], sda_i};
    end

  wire scl_now  = scl_s[SYNC-1];
  wire scl_old  = scl_s[SYNC];
  wire sda_now  = sda_s[SYNC-1];
  wire sda_old  = sda_s[SYNC];
  wire start    = scl_now & scl_old & sda_old & ~sda_now;
  wire stop     = scl_now & scl_old & ~sda_old & sda_now;
  wire scl_rise = scl_now & ~scl_old;
  wire scl_fall = ~scl_now & scl_old;
  wire addr_hit = (shf[7:1] == strap_addr) || (shf[7:1] == GLOBAL_ADDR);
  wire active   = (st == S_ADDR) || (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      nbyte    <= '0;
      shf      <= '0;
      hold     <= '0;
      sda_oe   <= 1'b0;
      word_o   <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (start) begin
        st      <= S_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop) begin
        st      <= S_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (active) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shf     <= {shf[6:0], sda_now};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          if (st == S_ADDR) begin
            if (addr_hit && !shf[0]) sda_oe <= 1'b1;
            else                     st     <= S_SKIP;
          end else if (nbyte != 2'd3) begin
            sda_oe <= 1'b1;
            nbyte  <= nbyte + 2'd1;
            case (nbyte)
              2'd0:    hold[15:8] <= shf;
              2'd1:    hold[7:0]  <= shf;
              default: begin
                word_o   <= {hold, shf};
                word_vld <= 1'b1;
              end
            endcase
          end
        end else if (scl_fall && bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          if (st == S_ADDR) begin
            st    <= S_DATA;
            nbyte <= '0;
          end
        end
      end
    end
endmodule

module i2c_word_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [23:0] word_o,
  input logic        word_vld
);
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  p_oe_fall_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
  p_word_only_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_vld);
  p_word_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> !scl_i);
endmodule

bind i2c_word_rx i2c_word_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .word_o(word_o), .word_vld(word_vld)
);

// File: tb/tb_i2c_word_rx.sv
module tb_i2c_word_rx;
  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [6:0] strap = 7'h2A;
  wire  sda_oe, word_vld;
  wire  [23:0] word_o;
  wire  sda_line = sda_m & ~sda_oe;
  int   errors = 0, checks = 0, vld_cnt = 0, run_len = 0, max_run = 0;
  logic [23:0] last_word = '0;
  logic oe_pre, oe_post;

  always #2.5 clk = ~clk;

  i2c_word_rx dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_addr(strap), .sda_oe(sda_oe), .word_o(word_o), .word_vld(word_vld));

  always @(negedge clk) begin
    if (word_vld) begin
      vld_cnt++;
      last_word = word_o;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * 8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(1); scl_m = 1; wq(1); sda_m = 0; wq(1); scl_m = 0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(1); scl_m = 1; wq(1); sda_m = 1; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1; wq(2);
      if (i == 0) oe_pre = sda_oe;
      scl_m = 0; wq(1);
    end
    sda_m = 1; wq(1); scl_m = 1; wq(1);
    ack = !sda_line;
    wq(1); scl_m = 0; wq(1);
    oe_post = sda_oe;
  endtask

  task automatic frame(input logic [6:0] a, input int nbytes, input logic [31:0] data,
                       output bit aack, output logic [3:0] dack);
    bit k;
    bus_start();
    send_byte({a, 1'b0}, aack);
    dack = '0;
    for (int j = 0; j < nbytes; j++) begin
      send_byte(data[31 - 8*j -: 8], k);
      dack[j] = k;
    end
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    logic [3:0] d;
    int base;
    repeat (4) @(negedge clk);
    chk(sda_oe == 0, "R1 sda_oe in reset", sda_oe, 0);
    chk(word_vld == 0, "R1 word_vld in reset", word_vld, 0);
    rst_n = 1;
    wq(2);
    chk(sda_oe == 0 && vld_cnt == 0, "R1 idle after reset", sda_oe, 0);

    for (int x = 0; x < 128; x++) begin
      bit exp_ack;
      exp_ack = (x == strap) || (x == 7'h73);
      bus_start();
      send_byte({x[6:0], 1'b0}, a);
      bus_stop();
      chk(a == exp_ack, exp_ack ? "R3 address acked" : "R4 address refused", a, exp_ack);
    end
    chk(vld_cnt == 0, "R4 no word from address sweep", vld_cnt, 0);

    base = vld_cnt;
    frame(strap, 3, 32'hA55A_C300, a, d);
    chk(oe_pre == 0 && oe_post == 0, "R10 ack window bounded", {oe_pre, oe_post}, 0);
    bus_stop();
    chk(a && d == 4'b0111, "R2 own write acks", {a, d}, 5'b10111);
    chk(vld_cnt == base + 1, "R2 one word", vld_cnt - base, 1);
    chk(last_word == 24'hA55AC3, "R2 word packing", last_word, 24'hA55AC3);

    base = vld_cnt;
    frame(7'h73, 3, 32'h0123_4500, a, d);
    bus_stop();
    chk(a && d == 4'b0111, "R3 global write acks", {a, d}, 5'b10111);
    chk(vld_cnt == base + 1 && last_word == 24'h012345, "R3 global word", last_word, 24'h012345);

    base = vld_cnt;
    bus_start();
    send_byte({strap, 1'b1}, a);
    chk(!a, "R5 read not acked", a, 0);
    for (int j = 0; j < 3; j++) begin
      bit k;
      send_byte(8'h3C, k);
      chk(!k, "R5 bytes after read ignored", k, 0);
    end
    bus_stop();
    chk(vld_cnt == base, "R5 no word after read", vld_cnt - base, 0);

    base = vld_cnt;
    frame(strap, 4, 32'hFF00_FFEE, a, d);
    bus_stop();
    chk(d == 4'b0111, "R6 fourth byte refused", d, 4'b0111);
    chk(vld_cnt == base + 1 && last_word == 24'hFF00FF, "R6 single word", last_word, 24'hFF00FF);

    base = vld_cnt;
    frame(strap, 2, 32'h1122_0000, a, d);
    bus_stop();
    chk(vld_cnt == base, "R7 stop aborts", vld_cnt - base, 0);
    frame(strap, 3, 32'h7788_9900, a, d);
    bus_stop();
    chk(vld_cnt == base + 1 && last_word == 24'h778899, "R7 next frame after abort", last_word, 24'h778899);

    base = vld_cnt;
    frame(7'h73, 2, 32'hDEAD_0000, a, d);
    frame(strap, 3, 32'h0F1E_2D00, a, d);
    bus_stop();
    chk(a && d == 4'b0111, "R8 frame after repeated start acked", {a, d}, 5'b10111);
    chk(vld_cnt == base + 1 && last_word == 24'h0F1E2D, "R8 only new frame word", last_word, 24'h0F1E2D);

    chk(max_run == 1, "R9 strobe width", max_run, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule